// File: doc/BRIEF.md
# Transmit Channel Status and Error Monitor

This block watches a set of transmit DMA channels and reports their condition to software. Each channel holds a run mode, a credit-gating enable and a credit counter. It also holds a one-entry command slot that a scheduler activate loads and a frame-complete pulse frees, and a count of issued requests that have not yet been acknowledged. From this state the block drives a per-channel request permission, a shared status word and a shared error word.

Software writes channel configuration, credit reloads and write-one-to-clear error masks through plain single-cycle strobes. The scheduler, the DMA datapath, the TX FIFO and the memory fabric feed plain event pulses. No port carries a data stream, so the block has no valid/ready handshake and never applies back-pressure. Every event is taken in the cycle it is presented. All outputs come from registers and change one clock after the event that causes them.

Top module: `tx_chan_monitor`

## Requirements
- R1: After reset all modes are off (00), gating is disabled, credits are 0, every slot is empty, no request is outstanding, `err_o` is 0 and `status_o` is 0xFFFF0000.
- R2: Mode code 10 is run, 01 is drain and 00 is off (11 acts as off). An activate loads a channel's slot only in run mode. In drain and off modes an activate is ignored and raises no error.
- R3: `req_ok_o[c]` is high when channel c's slot is occupied, its mode is run or drain, and either gating is disabled or its credit is nonzero.
- R4: A credit write loads the counter. Each issued request decrements it. It never goes below 0. A write in the same cycle as an issue takes priority.
- R5: `status_o[24+c]` is 1 when channel c's slot is empty. `status_o[16+c]` is 1 when channel c has no outstanding request (issue +1, acknowledge -1). `status_o[15:0]` reads 0.
- R6: `err_o[31]` latches an internal memory address fault.
- R7: `err_o[30]` latches a host dword count mismatch.
- R8: `err_o[9+c]` latches when an accepted activate finds channel c's slot occupied and no frame-complete pulse arrives in the same cycle.
- R9: `err_o[c]` latches when `fifo_full[c]` is high while channel c's credit is nonzero.
- R10: Error bits are sticky until software writes 1 to them through `err_clr_mask`. If a new event arrives in the same cycle as its clear, the bit stays set.
- R11: Error bits 29:17 and 8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | CHW | Channel addressed by the configuration write |
| cfg_mode | input | 2 | Mode code: 00 off, 01 drain, 10 run |
| cfg_credit_en | input | 1 | Credit gating enable written with the mode |
| crd_we | input | 1 | Credit reload strobe |
| crd_chan | input | CHW | Channel addressed by the credit reload |
| crd_val | input | CW | Credit reload value |
| err_clr_we | input | 1 | Error write-one-to-clear strobe |
| err_clr_mask | input | 32 | Bits to clear |
| act_cmd | input | NCH | Scheduler activate, one per channel |
| frame_done | input | NCH | Frame complete, frees the slot |
| req_issue | input | NCH | Request issued by the channel |
| req_ack | input | NCH | Outstanding request completed |
| fifo_full | input | NCH | TX FIFO full indication per channel |
| addr_fault | input | 1 | Internal memory address fault |
| dword_short | input | 1 | Host dword count mismatch |
| status_o | output | 32 | Slot-empty and no-pending flags |
| err_o | output | 32 | Sticky error word |
| req_ok_o | output | NCH | Request permission per channel |
| credit_o | output | NCH*CW | Credit counters, channel c at [c*CW +: CW] |

## Verification
The bench builds the block with eight channels, a 4-bit credit counter and a 3-bit outstanding counter. The narrow credit lets the bench drain a counter to zero within a few cycles, so saturation at zero, reload priority and the zero-credit cases of the desync error can all be reached. It also covers every mode code and the simultaneous activate/complete and set/clear collisions.

// File: rtl/txmon_pkg.sv
package txmon_pkg;
  typedef enum logic [1:0] {
    CH_OFF   = 2'b00,
    CH_DRAIN = 2'b01,
    CH_RUN   = 2'b10,
    CH_RSVD  = 2'b11
  } ch_mode_e;

  localparam int MAX_CH         = 8;
  localparam int ERR_ADDR_BIT   = 31;
  localparam int ERR_DW_BIT     = 30;
  localparam int ERR_OVF_LSB    = 9;
  localparam int ERR_CRD_LSB    = 0;
  localparam int STAT_EMPTY_LSB = 24;
  localparam int STAT_IDLE_LSB  = 16;
endpackage

// File: rtl/txmon_chan.sv
module txmon_chan
  import txmon_pkg::*;
#(
  parameter int CW = 8,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  ch_mode_e      cfg_mode,
  input  logic          cfg_cen,
  input  logic          crd_we,
  input  logic [CW-1:0] crd_val,
  input  logic          act,
  input  logic          done,
  input  logic          issue,
  input  logic          ack,
  input  logic          full,
  output logic          occ_o,
  output logic          idle_o,
  output logic          req_ok_o,
  output logic [CW-1:0] credit_o,
  output logic          ovf_o,
  output logic          desync_o
);
  localparam logic [OW-1:0] OUT_MAX = '1;

  ch_mode_e      mode_q;
  logic          cen_q;
  logic [CW-1:0] credit_q;
  logic          occ_q;
  logic [OW-1:0] outst_q;
  logic          load;
  logic          crd_nz;

  assign crd_nz   = (credit_q != '0);
  assign load     = act && (mode_q == CH_RUN);
  assign ovf_o    = load && occ_q && !done;
  assign desync_o = full && crd_nz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= CH_OFF;
      cen_q    <= 1'b0;
      credit_q <= '0;
      occ_q    <= 1'b0;
      outst_q  <= '0;
    end else begin
      if (cfg_we) begin
        mode_q <= cfg_mode;
        cen_q  <= cfg_cen;
      end
      if (crd_we)
        credit_q <= crd_val;
      else if (issue && crd_nz)
        credit_q <= credit_q - 1'b1;
      occ_q <= load || (occ_q && !done);
      case ({issue, ack})
        2'b10: if (outst_q != OUT_MAX) outst_q <= outst_q + 1'b1;
        2'b01: if (outst_q != '0) outst_q <= outst_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign occ_o    = occ_q;
  assign idle_o   = (outst_q == '0);
  assign credit_o = credit_q;
  assign req_ok_o = occ_q && (mode_q == CH_RUN || mode_q == CH_DRAIN) &&
                    (!cen_q || crd_nz);
endmodule

// File: rtl/txmon_err.sv
module txmon_err (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] set_i,
  input  logic        clr_we,
  input  logic [31:0] clr_mask,
  output logic [31:0] err_o
);
  logic [31:0] err_q;
  logic [31:0] clr;

  assign clr = clr_we ? clr_mask : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (err_q & ~clr) | set_i;
  end

  assign err_o = err_q;
endmodule

// File: rtl/tx_chan_monitor.sv
module tx_chan_monitor
  import txmon_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 8,
  parameter int OW  = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_chan,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_credit_en,
  input  logic              crd_we,
  input  logic [CHW-1:0]    crd_chan,
  input  logic [CW-1:0]     crd_val,
  input  logic              err_clr_we,
  input  logic [31:0]       err_clr_mask,
  input  logic [NCH-1:0]    act_cmd,
  input  logic [NCH-1:0]    frame_done,
  input  logic [NCH-1:0]    req_issue,
  input  logic [NCH-1:0]    req_ack,
  input  logic [NCH-1:0]    fifo_full,
  input  logic              addr_fault,
  input  logic              dword_short,
  output logic [31:0]       status_o,
  output logic [31:0]       err_o,
  output logic [NCH-1:0]    req_ok_o,
  output logic [NCH*CW-1:0] credit_o
);
  logic [NCH-1:0] occ, idle, ovf, desync;
  logic [31:0]    err_set;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    txmon_chan #(.CW(CW), .OW(OW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we && (cfg_chan == CHW'(c))),
      .cfg_mode (ch_mode_e'(cfg_mode)),
      .cfg_cen  (cfg_credit_en),
      .crd_we   (crd_we && (crd_chan == CHW'(c))),
      .crd_val  (crd_val),
      .act      (act_cmd[c]),
      .done     (frame_done[c]),
      .issue    (req_issue[c]),
      .ack      (req_ack[c]),
      .full     (fifo_full[c]),
      .occ_o    (occ[c]),
      .idle_o   (idle[c]),
      .req_ok_o (req_ok_o[c]),
      .credit_o (credit_o[c*CW +: CW]),
      .ovf_o    (ovf[c]),
      .desync_o (desync[c])
    );
  end

  always_comb begin
    err_set = '0;
    err_set[ERR_ADDR_BIT] = addr_fault;
    err_set[ERR_DW_BIT]   = dword_short;
    for (int c = 0; c < NCH; c++) begin
      err_set[ERR_OVF_LSB + c] = ovf[c];
      err_set[ERR_CRD_LSB + c] = desync[c];
    end
  end

  always_comb begin
    status_o = '0;
    for (int c = 0; c < NCH; c++) begin
      status_o[STAT_EMPTY_LSB + c] = !occ[c];
      status_o[STAT_IDLE_LSB + c]  = idle[c];
    end
  end

  txmon_err u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (err_set),
    .clr_we   (err_clr_we),
    .clr_mask (err_clr_mask),
    .err_o    (err_o)
  );
endmodule

// File: rtl/txmon_chk.sv
module txmon_chk #(
  parameter int NCH = 8,
  parameter int CW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_clr_we,
  input logic [31:0]       err_clr_mask,
  input logic              addr_fault,
  input logic              dword_short,
  input logic [NCH-1:0]    fifo_full,
  input logic              crd_we,
  input logic [CHW-1:0]    crd_chan,
  input logic [NCH-1:0]    req_issue,
  input logic [31:0]       status_o,
  input logic [31:0]       err_o,
  input logic [NCH-1:0]    req_ok_o,
  input logic [NCH*CW-1:0] credit_o
);
  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(err_o) & ~($past(err_clr_we) ? $past(err_clr_mask) : 32'd0)
              & ~err_o) == 32'd0));

  // R11
  rsvd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o & 32'h3FFE_0100) == 32'd0);

  // R6
  addr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_fault |=> err_o[31]);

  // R7
  dword_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dword_short |=> err_o[30]);

  // R3
  ok_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok_o & status_o[24 +: NCH]) == '0);

  // R5
  status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[15:0] == 16'd0);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R9
    desync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full[c] && credit_o[c*CW +: CW] != '0) |=> err_o[c]);
    // R4
    credit_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (credit_o[c*CW +: CW] == '0 && !(crd_we && crd_chan == CHW'(c)))
        |=> credit_o[c*CW +: CW] == '0);
  end
endmodule

bind tx_chan_monitor txmon_chk #(.NCH(NCH), .CW(CW)) u_chk (.*);

// File: tb/tx_chan_monitor_test.sv
module tx_chan_monitor_test;
  localparam int NCH = 8;
  localparam int CW  = 4;
  localparam int OW  = 3;
  localparam int CHW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              cfg_we = 0, cfg_credit_en = 0, crd_we = 0, err_clr_we = 0;
  logic [CHW-1:0]    cfg_chan = 0, crd_chan = 0;
  logic [1:0]        cfg_mode = 0;
  logic [CW-1:0]     crd_val = 0;
  logic [31:0]       err_clr_mask = 0;
  logic [NCH-1:0]    act_cmd = 0, frame_done = 0, req_issue = 0, req_ack = 0, fifo_full = 0;
  logic              addr_fault = 0, dword_short = 0;
  logic [31:0]       status_o, err_o;
  logic [NCH-1:0]    req_ok_o;
  logic [NCH*CW-1:0] credit_o;

  tx_chan_monitor #(.NCH(NCH), .CW(CW), .OW(OW)) uut (.*);

  typedef struct {
    string             tag;
    logic [31:0]       err;
    logic [31:0]       stat;
    logic [NCH-1:0]    ok;
    logic [NCH*CW-1:0] cred;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int nvec = 0, nbad = 0;
  bit finished = 0;

  // reference state kept from the requirements
  int          m_mode[NCH], m_cen[NCH], m_cred[NCH], m_occ[NCH], m_out[NCH];
  logic [31:0] m_err;

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      nvec++;
      if (err_o !== cur.err || status_o !== cur.stat ||
          req_ok_o !== cur.ok || credit_o !== cur.cred) begin
        nbad++;
        $display("FAIL %s: err %h/%h stat %h/%h ok %b/%b cred %h/%h (actual/expected)",
                 cur.tag, err_o, cur.err, status_o, cur.stat,
                 req_ok_o, cur.ok, credit_o, cur.cred);
      end
    end
  end

  task automatic tick(input string tag);
    logic [31:0] ne;
    exp_t e;
    ne = m_err & ~(err_clr_we ? err_clr_mask : 32'd0);
    if (addr_fault)  ne[31] = 1'b1;
    if (dword_short) ne[30] = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      if (fifo_full[c] && m_cred[c] != 0) ne[c] = 1'b1;
      if (act_cmd[c] && m_mode[c] == 2) begin
        if (m_occ[c] != 0 && !frame_done[c]) ne[9+c] = 1'b1;
        m_occ[c] = 1;
      end else if (frame_done[c]) m_occ[c] = 0;
      if (crd_we && crd_chan == c) m_cred[c] = crd_val;
      else if (req_issue[c] && m_cred[c] > 0) m_cred[c]--;
      if (req_issue[c] && !req_ack[c]) m_out[c]++;
      if (req_ack[c] && !req_issue[c] && m_out[c] > 0) m_out[c]--;
      if (cfg_we && cfg_chan == c) begin
        m_mode[c] = cfg_mode;
        m_cen[c]  = cfg_credit_en;
      end
    end
    m_err = ne;
    e.tag = tag; e.err = m_err; e.stat = 0; e.ok = 0; e.cred = 0;
    for (int c = 0; c < NCH; c++) begin
      e.stat[24+c] = (m_occ[c] == 0);
      e.stat[16+c] = (m_out[c] == 0);
      e.ok[c] = (m_occ[c] != 0) && (m_mode[c] == 1 || m_mode[c] == 2) &&
                (m_cen[c] == 0 || m_cred[c] != 0);
      e.cred[c*CW +: CW] = CW'(m_cred[c]);
    end
    @(posedge clk);
    exp_q.push_back(e);
    @(negedge clk);
    cfg_we = 0; crd_we = 0; err_clr_we = 0; err_clr_mask = 0;
    act_cmd = 0; frame_done = 0; req_issue = 0; req_ack = 0; fifo_full = 0;
    addr_fault = 0; dword_short = 0;
  endtask

  task automatic set_cfg(input int ch, input int mode, input bit cen);
    cfg_we = 1; cfg_chan = CHW'(ch); cfg_mode = 2'(mode); cfg_credit_en = cen;
  endtask

  task automatic set_crd(input int ch, input int val);
    crd_we = 1; crd_chan = CHW'(ch); crd_val = CW'(val);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_mode[c] = 0; m_cen[c] = 0; m_cred[c] = 0; m_occ[c] = 0; m_out[c] = 0;
    end
    m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick("R1 reset state");
    set_cfg(0, 2, 1);          tick("R2 run mode ch0");
    set_crd(0, 2);             tick("R4 credit reload");
    act_cmd[0] = 1;            tick("R2 R3 R5 activate in run");
    req_issue[0] = 1;          tick("R4 R5 issue one");
    req_issue[0] = 1;          tick("R3 R4 credit reaches zero");
    req_issue[0] = 1;          tick("R4 floor at zero");
    for (int i = 0; i < 3; i++) begin
      req_ack[0] = 1;          tick("R5 acknowledge");
    end
    act_cmd[0] = 1;            tick("R8 activate into full slot");
    act_cmd[0] = 1; frame_done[0] = 1; tick("R8 activate with complete");
    fifo_full[0] = 1;          tick("R9 full at zero credit");
    set_crd(0, 3);             tick("R4 reload");
    fifo_full[0] = 1;          tick("R9 full with credit");
    addr_fault = 1;            tick("R6 address fault");
    dword_short = 1;           tick("R7 dword mismatch");
    err_clr_we = 1; err_clr_mask = 32'h8000_0000; tick("R10 clear one bit");
    err_clr_we = 1; err_clr_mask = 32'h4000_0000; dword_short = 1;
                               tick("R10 set beats clear");
    set_cfg(3, 1, 0);          tick("R2 drain ch3");
    act_cmd[3] = 1;            tick("R2 activate ignored in drain");
    set_cfg(3, 3, 0);          tick("R2 code 11");
    act_cmd[3] = 1;            tick("R2 activate ignored in 11");
    set_cfg(5, 2, 0);          tick("R2 run ch5 ungated");
    act_cmd[5] = 1;            tick("R3 ungated zero credit");
    set_cfg(5, 1, 0);          tick("R3 drain keeps permission");
    frame_done[5] = 1;         tick("R3 slot freed");
    set_cfg(5, 0, 0);          tick("R3 off");
    set_crd(0, 7); req_issue[0] = 1; tick("R4 write beats issue");
    fifo_full[7] = 1; set_crd(7, 1); tick("R9 old credit used");
    fifo_full[7] = 1;          tick("R9 credit ch7");
    err_clr_we = 1; err_clr_mask = 32'hFFFF_FFFF; tick("R10 R11 clear all");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: run did not complete (actual hang, expected finish)");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule